// File: doc/BRIEF.md
# Token-Arbitrated Reversible Link Controller

This block lets two neighbouring router ports share a single data link whose direction is chosen at run time, instead of dedicating one link to each direction. One controller sits at each end of the link. At any moment one of them holds a token and is the only one allowed to drive the shared wires. The other listens and hands each arriving flit to its local input buffer.

The token moves only between packets. When the holder is between packets and the opposite end is asking for the link, the holder sends a one-cycle handoff pulse, releases its driver in that same cycle and becomes the listener. The other end becomes the sender on the next clock edge. Each sender keeps a count of free slots in the far input buffer. The count goes down for every flit sent and up for every credit pulse returned from the far side, and a flit leaves only while the count is above zero.

The wrapper holds both controllers and the shared wires, which are modelled as an OR of the data driven by each end, gated by that end's output enable. All control logic runs on one link clock.

Top module: `vlink_duplex`

## Requirements
- R1: After reset, the end selected by parameter HOME holds the token, its driver enable is high and its request line is low. The other end does not hold the token and does not drive.
- R2: The driver enables of the two ends are never high in the same cycle, and only the end holding the token may raise its enable.
- R3: Each sender's credit level starts at DEPTH. It drops by one for each flit it pops and rises by one for each credit pulse from the far input buffer. A flit is popped only while the level is above zero, so the far buffer never holds more than DEPTH flits.
- R4: The token never moves while a packet is open, meaning after a flit with end-of-packet bit 0 has left and before a flit with end-of-packet bit 1 has left. Flits of one packet are never interleaved with flits going the other way.
- R5: A handoff pulse on an end's token line happens only while the other end's request line is high. Without such a request, the holder keeps the token indefinitely.
- R6: In the cycle an end pulses its token line, neither driver enable is high. On the next cycle the other end holds the token, and only from that cycle may it drive.
- R7: An end's request line equals "its output buffer is non-empty and it does not hold the token".
- R8: A flit popped from one end's output buffer appears in the same cycle on the other end's receive outputs, with data and end-of-packet bit unchanged. Nothing appears on the receive outputs in any other cycle.
- R9: At a packet boundary a pending far request wins over further local packets. The one exception is an end that has just received the token and has a flit waiting: it sends one whole packet before it may yield. Traffic in both directions therefore alternates packet by packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 2 | Per end: output buffer has a flit at its head |
| src_flit | input | 2xDATA_W | Per end: head flit data |
| src_eop | input | 2 | Per end: head flit closes its packet |
| src_pop | output | 2 | Per end: head flit leaves on the link this cycle |
| snk_valid | output | 2 | Per end: a flit arrives for the local input buffer |
| snk_flit | output | 2xDATA_W | Per end: arriving flit data |
| snk_eop | output | 2 | Per end: arriving flit closes its packet |
| snk_credit | input | 2 | Per end: local input buffer freed one slot |
| link_req | output | 2 | Per end: request for the link |
| link_tok | output | 2 | Per end: one-cycle token handoff pulse to the far end |
| link_oe | output | 2 | Per end: driver enable onto the shared link |
| holds_token | output | 2 | Per end: this end is in send mode |

## Verification
The main function is tried with traffic from one end only, from the other end only, from both ends loaded in the same cycle, and with several queued packets of unequal length on each side. One-sided traffic shows that the holder keeps the link when no one asks for it. Simultaneous loading separates the packet-by-packet alternation rule from a greedy holder, and the handoff count and final holder tell these apart. A stalled far buffer with an open packet shows that credits throttle the sender at exactly DEPTH flits and that a request arriving mid-packet cannot move the token until the closing flit has gone.

// File: rtl/vlink_pkg.sv
package vlink_pkg;

   typedef enum logic {
      LM_RECV = 1'b0,
      LM_SEND = 1'b1
   } lmode_e;

   function automatic int unsigned lvl_width(input int unsigned depth);
      return (depth < 1) ? 1 : $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/vlink_credit.sv
module vlink_credit #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic give,
   output logic has_credit
);
   localparam int unsigned CW = vlink_pkg::lvl_width(DEPTH);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("vlink_credit: DEPTH must be at least 1");
   end

   logic [CW-1:0] level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= FULL;
      end else begin
         case ({take, give})
            2'b10:   level <= level - 1'b1;
            2'b01:   level <= level + 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign has_credit = (level != '0);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL);
   p_take_backed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> level != '0);
   p_give_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (give && !take) |-> level < FULL);

endmodule

// File: rtl/vlink_token_fsm.sv
module vlink_token_fsm
   import vlink_pkg::*;
#(
   parameter bit HOME = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tok_in,
   input  logic   far_req,
   input  logic   pkt_open,
   input  logic   has_data,
   input  logic   eop_sent,
   output lmode_e mode,
   output logic   pass_now
);
   logic fresh;

   assign pass_now = (mode == LM_SEND) && !pkt_open && far_req
                     && !(fresh && has_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= HOME ? LM_SEND : LM_RECV;
         fresh <= HOME;
      end else begin
         if (mode == LM_SEND && pass_now)
            mode <= LM_RECV;
         else if (mode == LM_RECV && tok_in)
            mode <= LM_SEND;
         if (tok_in)
            fresh <= 1'b1;
         else if (eop_sent || pass_now)
            fresh <= 1'b0;
      end
   end

   p_pass_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pass_now |-> far_req);
   p_keep_token_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LM_SEND && !far_req) |=> mode == LM_SEND);
   p_pass_to_recv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pass_now |=> mode == LM_RECV);
   p_tok_to_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tok_in |=> mode == LM_SEND);
   p_tok_only_listener_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tok_in |-> mode == LM_RECV);
   p_no_pass_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_open |-> !pass_now);

endmodule

// File: rtl/vlink_end.sv
module vlink_end
   import vlink_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4,
   parameter bit          HOME   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_flit,
   input  logic              src_eop,
   output logic              src_pop,
   input  logic              cred_ret,
   input  logic              tok_in,
   input  logic              far_req,
   output logic              tok_out,
   output logic              req_out,
   output logic              oe,
   output logic              holding,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_flit,
   output logic              tx_eop,
   input  logic              bus_valid,
   input  logic [DATA_W-1:0] bus_flit,
   input  logic              bus_eop,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_flit,
   output logic              rx_eop
);
   lmode_e mode;
   logic   pass_now;
   logic   has_credit;
   logic   pkt_open;
   logic   send_ok;

   vlink_token_fsm #(.HOME(HOME)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tok_in   (tok_in),
      .far_req  (far_req),
      .pkt_open (pkt_open),
      .has_data (src_valid),
      .eop_sent (send_ok && src_eop),
      .mode     (mode),
      .pass_now (pass_now)
   );

   vlink_credit #(.DEPTH(DEPTH)) u_cred (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (send_ok),
      .give       (cred_ret),
      .has_credit (has_credit)
   );

   always_comb begin
      oe       = (mode == LM_SEND) && !pass_now;
      send_ok  = oe && src_valid && has_credit;
      src_pop  = send_ok;
      tx_valid = send_ok;
      tx_flit  = send_ok ? src_flit : '0;
      tx_eop   = send_ok && src_eop;
      tok_out  = pass_now;
      holding  = (mode == LM_SEND);
      req_out  = src_valid && (mode == LM_RECV);
      rx_valid = (mode == LM_RECV) && bus_valid;
      rx_flit  = (mode == LM_RECV) ? bus_flit : '0;
      rx_eop   = (mode == LM_RECV) && bus_eop;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pkt_open <= 1'b0;
      else if (send_ok)
         pkt_open <= !src_eop;
   end

   p_release_on_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tok_out |-> !oe);
   p_whole_packet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tok_out |-> !pkt_open);
   p_req_not_holder_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_out |-> !holding);
   p_pop_has_flit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      src_pop |-> src_valid);
   p_listener_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !holding |-> !oe && !tx_valid);

endmodule

// File: rtl/vlink_duplex.sv
module vlink_duplex #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned HOME   = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             src_valid,
   input  logic [1:0][DATA_W-1:0] src_flit,
   input  logic [1:0]             src_eop,
   output logic [1:0]             src_pop,
   output logic [1:0]             snk_valid,
   output logic [1:0][DATA_W-1:0] snk_flit,
   output logic [1:0]             snk_eop,
   input  logic [1:0]             snk_credit,
   output logic [1:0]             link_req,
   output logic [1:0]             link_tok,
   output logic [1:0]             link_oe,
   output logic [1:0]             holds_token
);
   if (HOME > 1) begin : g_bad_home
      $error("vlink_duplex: HOME selects end 0 or end 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("vlink_duplex: DATA_W must be at least 1");
   end

   logic [1:0]             tx_valid;
   logic [1:0][DATA_W-1:0] tx_flit;
   logic [1:0]             tx_eop;
   logic                   bus_valid;
   logic [DATA_W-1:0]      bus_flit;
   logic                   bus_eop;

   // shared wires: each end's contribution is zero unless it drives
   assign bus_valid = |tx_valid;
   assign bus_flit  = tx_flit[0] | tx_flit[1];
   assign bus_eop   = |tx_eop;

   for (genvar g = 0; g < 2; g++) begin : g_end
      localparam bit IS_HOME = (g == HOME);
      vlink_end #(
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH),
         .HOME   (IS_HOME)
      ) u_end (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_valid (src_valid[g]),
         .src_flit  (src_flit[g]),
         .src_eop   (src_eop[g]),
         .src_pop   (src_pop[g]),
         .cred_ret  (snk_credit[1-g]),
         .tok_in    (link_tok[1-g]),
         .far_req   (link_req[1-g]),
         .tok_out   (link_tok[g]),
         .req_out   (link_req[g]),
         .oe        (link_oe[g]),
         .holding   (holds_token[g]),
         .tx_valid  (tx_valid[g]),
         .tx_flit   (tx_flit[g]),
         .tx_eop    (tx_eop[g]),
         .bus_valid (bus_valid),
         .bus_flit  (bus_flit),
         .bus_eop   (bus_eop),
         .rx_valid  (snk_valid[g]),
         .rx_flit   (snk_flit[g]),
         .rx_eop    (snk_eop[g])
      );
   end

   p_single_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(link_oe[0] && link_oe[1]));
   p_one_holder_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(holds_token) == 1);
   p_deliver_0to1_r8: assert property (@(posedge clk) disable iff (!rst_n)
      src_pop[0] |-> snk_valid[1] && snk_flit[1] == src_flit[0] && snk_eop[1] == src_eop[0]);
   p_deliver_1to0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      src_pop[1] |-> snk_valid[0] && snk_flit[0] == src_flit[1] && snk_eop[0] == src_eop[1]);
   p_handoff_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      link_tok[0] |=> holds_token[1]);

endmodule

// File: tb/sim_vlink_duplex.sv
module sim_vlink_duplex;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 4;
   localparam int CLK_P  = 10;
   localparam int NV     = 8;
   // per entry: packets end0, length end0, packets end1, length end1,
   //            expected holder afterwards, expected handoffs
   localparam int VT [NV][6] = '{
      '{1, 3, 0, 0, 0, 0},
      '{0, 0, 1, 2, 1, 1},
      '{1, 2, 1, 2, 1, 2},
      '{1, 1, 0, 0, 0, 1},
      '{1, 2, 1, 3, 0, 2},
      '{0, 0, 0, 0, 0, 0},
      '{2, 2, 0, 0, 0, 0},
      '{2, 3, 2, 1, 0, 4}
   };

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic [1:0]             src_valid;
   logic [1:0][DATA_W-1:0] src_flit;
   logic [1:0]             src_eop;
   logic [1:0]             src_pop;
   logic [1:0]             snk_valid;
   logic [1:0][DATA_W-1:0] snk_flit;
   logic [1:0]             snk_eop;
   logic [1:0]             snk_credit;
   logic [1:0]             link_req, link_tok, link_oe, holds_token;

   vlink_duplex #(.DATA_W(DATA_W), .DEPTH(DEPTH), .HOME(0)) u0 (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_flit(src_flit),
      .src_eop(src_eop), .src_pop(src_pop), .snk_valid(snk_valid),
      .snk_flit(snk_flit), .snk_eop(snk_eop), .snk_credit(snk_credit),
      .link_req(link_req), .link_tok(link_tok), .link_oe(link_oe),
      .holds_token(holds_token)
   );

   always #(CLK_P/2) clk = ~clk;

   int nchk = 0, nfail = 0;
   logic [DATA_W:0] smem [2][256];
   int wr[2], rd[2], occ[2], cred[2], serial[2];
   bit drain[2], tx_open[2], pend[2];
   int passes, pops[2];
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load(input int e, input int npk, input int len);
      for (int p = 0; p < npk; p++)
         for (int f = 0; f < len; f++) begin
            smem[e][wr[e]] = {(f == len-1), DATA_W'(e*4096 + serial[e])};
            serial[e]++;
            wr[e]++;
         end
   endtask

   task automatic step();
      @(negedge clk);
      for (int e = 0; e < 2; e++) begin
         src_valid[e]  = (rd[e] < wr[e]);
         src_flit[e]   = smem[e][rd[e] % 256][DATA_W-1:0];
         src_eop[e]    = src_valid[e] && smem[e][rd[e] % 256][DATA_W];
         snk_credit[e] = drain[e] && (occ[e] > 0);
      end
      #(CLK_P/4);
      chk(!(link_oe[0] && link_oe[1]), "R2 both drivers", int'(link_oe), 1);
      for (int e = 0; e < 2; e++) begin
         chk(!link_oe[e] || holds_token[e], "R2 non-holder drives", int'(link_oe), int'(holds_token));
         chk(link_req[e] == (src_valid[e] && !holds_token[e]), "R7 request line",
             int'(link_req[e]), int'(src_valid[e] && !holds_token[e]));
      end
      for (int e = 0; e < 2; e++) begin
         automatic int o = 1 - e;
         if (pend[e]) begin
            chk(holds_token[o] && !holds_token[e], "R6 holder after handoff",
                int'(holds_token), 1 << o);
            pend[e] = 1'b0;
         end
         if (link_tok[e]) begin
            chk(!link_oe[e] && !link_oe[o], "R6 drivers off at handoff", int'(link_oe), 0);
            chk(link_req[o], "R5 handoff without request", int'(link_req[o]), 1);
            chk(!tx_open[e], "R4 handoff inside packet", int'(tx_open[e]), 0);
            pend[e] = 1'b1;
            passes++;
         end
         if (src_pop[e]) begin
            chk(cred[e] > 0, "R3 pop without credit", cred[e], 1);
            chk(snk_valid[o] && snk_flit[o] == src_flit[e] && snk_eop[o] == src_eop[e],
                "R8 delivered flit", int'(snk_flit[o]), int'(src_flit[e]));
            chk(!tx_open[o], "R4 interleaved packets", int'(tx_open[o]), 0);
            tx_open[e] = !src_eop[e];
            rd[e]++;
            pops[e]++;
            cred[e]--;
         end else if (snk_valid[o]) begin
            chk(1'b0, "R8 phantom flit", int'(snk_flit[o]), 0);
         end
         if (snk_credit[o]) cred[e]++;
      end
      for (int e = 0; e < 2; e++) begin
         if (snk_valid[e]) occ[e]++;
         if (snk_credit[e]) occ[e]--;
         if (occ[e] > DEPTH) chk(1'b0, "R3 far buffer overflow", occ[e], DEPTH);
      end
   endtask

   task automatic run_until_idle(input string tag);
      int cyc = 0;
      while ((rd[0] < wr[0] || rd[1] < wr[1] || occ[0] > 0 || occ[1] > 0) && cyc < 300) begin
         step();
         cyc++;
      end
      if (cyc >= 300) chk(1'b0, {tag, " stuck"}, cyc, 300);
      for (int i = 0; i < 3; i++) step();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
   endtask

   initial begin
      #(CLK_P * 60000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      src_valid = '0; src_flit = '0; src_eop = '0; snk_credit = '0;
      for (int e = 0; e < 2; e++) begin
         wr[e] = 0; rd[e] = 0; occ[e] = 0; cred[e] = DEPTH; serial[e] = 0;
         drain[e] = 1'b1; tx_open[e] = 1'b0; pend[e] = 1'b0; pops[e] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk(holds_token == 2'b01, "R1 reset holder", int'(holds_token), 1);
      chk(link_oe == 2'b01, "R1 reset drivers", int'(link_oe), 1);
      chk(link_req == 2'b00 && snk_valid == 2'b00, "R1 reset quiet",
          int'({link_req, snk_valid}), 0);

      // table of traffic patterns: R9 alternation, R5 holder keeps token
      for (int v = 0; v < NV; v++) begin
         automatic int before0 = pops[0];
         automatic int before1 = pops[1];
         passes = 0;
         load(0, VT[v][0], VT[v][1]);
         load(1, VT[v][2], VT[v][3]);
         run_until_idle("R9 table");
         chk(pops[0] - before0 == VT[v][0]*VT[v][1], "R8 flits from end0",
             pops[0] - before0, VT[v][0]*VT[v][1]);
         chk(pops[1] - before1 == VT[v][2]*VT[v][3], "R8 flits from end1",
             pops[1] - before1, VT[v][2]*VT[v][3]);
         chk(holds_token[VT[v][4]], "R9 holder after pattern", int'(holds_token), 1 << VT[v][4]);
         chk(passes == VT[v][5], "R9 handoff count", passes, VT[v][5]);
      end

      // directed: far buffer stalls mid-packet (R3), request mid-packet (R4)
      begin
         automatic int base = pops[0];
         passes = 0;
         drain[1] = 1'b0;
         load(0, 1, 6);
         step(); step();
         load(1, 1, 2);
         for (int i = 0; i < 10; i++) step();
         chk(pops[0] - base == DEPTH, "R3 stall at credit limit", pops[0] - base, DEPTH);
         chk(passes == 0 && holds_token == 2'b01, "R4 token held in open packet",
             passes, 0);
         chk(link_req[1], "R7 request while waiting", int'(link_req[1]), 1);
         drain[1] = 1'b1;
         run_until_idle("R3 drain");
         chk(pops[0] - base == 6, "R3 packet completes after credits", pops[0] - base, 6);
         chk(passes == 1 && holds_token == 2'b10, "R5 handoff after closing flit",
             passes, 1);
      end

      // directed: holder with no request keeps the token over a long idle (R5)
      for (int i = 0; i < 20; i++) step();
      chk(holds_token == 2'b10 && link_tok == 2'b00, "R5 idle holder keeps token",
          int'(holds_token), 2);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule